// File: doc/BRIEF.md
# Line-interface PHY mode register with interrupt status bank

This block holds the control and status state a host uses to configure a line-interface PHY. A single 8-bit mode register sets the loopback path, the format of filler cells inserted into empty slots, the receive clock source, and what the receive clock does when the clock recovery loop has lost lock. The block drives these settings out as decoded control lines. The clock multiplexers, loopback paths and cell generators that use them are outside this block.

The two low bits of the mode register choose how a bank of interrupt status bits responds to their sources and to host reads. In sticky mode a source sets its bit, and the bit stays set until the host reads the status register. In level mode the bit follows the source and reads have no effect. In read-clear mode a rising source edge sets the bit, and any read clears it, even while the cause is still present. A per-bit enable register gates the bits onto one registered interrupt request line.

The host reaches three byte-wide locations through a simple strobe port: the mode register at 04H, the status register at 05H (read only), and the enable register at 06H. Any read of 05H with the read strobe high counts as a clearing read.

Top module: `phy_ctl_irq`

## Requirements
- R1: After reset the mode register reads 00H, every status bit is 0, every enable bit is 0, and the interrupt request is low.
- R2: A write to address 04H stores bits [6:0] of the write data, subject to R3. A read of 04H returns them, with bit 7 always reading as 0.
- R3: A write to 04H whose bits [4:3] are 11 leaves the loopback field at its previous value. The other fields of that write are still stored.
- R4: The outputs follow the mode register as follows: `lb_sel` = bits [4:3] (00 normal, 01 line-side loop ahead of serial/parallel conversion, 10 cell-side loop through it); `free_unassigned` = bit 5 (1 unassigned cells, 0 idle cells); `rx_synth` = bit 2 (1 transmit synthesizer clock, 0 recovered clock); `ool_keep` = bit 6 (1 keep the recovered clock when out of lock, 0 fall back to the transmit clock).
- R5: With mode bits [1:0] = 00 (sticky), a status bit is set at the clock edge where its source is high. It stays set after the source falls, and it clears at the edge of a clearing read when the source is low.
- R6: In sticky mode, a clearing read in a cycle where the source is still high leaves the bit set.
- R7: With mode bits = 01 (level), each status bit equals its source as sampled at the previous clock edge, and clearing reads have no effect.
- R8: With mode bits = 10 (read-clear), a status bit sets at the edge after its source rises from 0 to 1. A clearing read clears it even if the source stays high. A read in the same cycle as the rising edge also leaves it clear, and the bit sets again only on a later rising edge.
- R9: Mode bits = 11 behave exactly like 10.
- R10: The interrupt request is the OR of (status AND enable), registered one cycle after the status. The enable register at 06H reads back its low NSRC bits, with the upper bits reading 0.
- R11: A read of 05H returns the status bits in the low NSRC bits, with zeros above them. Writes to 05H change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; with addr 05H it is a clearing read |
| rdata | output | 8 | Read data, combinational from addr |
| src | input | NSRC | Interrupt source levels |
| stat | output | NSRC | Status bits |
| irq | output | 1 | Interrupt request |
| lb_sel | output | 2 | Loopback select |
| free_unassigned | output | 1 | Filler cell format select |
| rx_synth | output | 1 | Receive clock source select |
| ool_keep | output | 1 | Out-of-lock clock behaviour |

## Verification
A clearing read can land in the same cycle that a source is high or rising. The outcome depends on the mode: in sticky mode the source wins, and in read-clear mode the read wins. The bench sweeps every mode code with a pseudo-random source and read pattern that makes these collisions often, and it also sets up each collision on purpose. An arithmetic model in the bench predicts every status bit and the delayed interrupt after each edge, and it tags each mismatch with the rule that applies to that mode and collision.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;

   typedef enum logic [1:0] {
      IM_STICKY = 2'd0,
      IM_LEVEL  = 2'd1,
      IM_RDCLR  = 2'd2
   } irq_mode_e;

   typedef struct packed {
      logic       ool_keep;
      logic       free_unassigned;
      logic [1:0] lb;
      logic       rx_synth;
      logic [1:0] imode;
   } mode_fields_t;

   localparam logic [1:0] LB_ILLEGAL = 2'b11;

   function automatic irq_mode_e decode_imode(input logic [1:0] code);
      if (code[1])      return IM_RDCLR;
      else if (code[0]) return IM_LEVEL;
      else              return IM_STICKY;
   endfunction

endpackage

// File: rtl/phy_mode_reg.sv
module phy_mode_reg
   import phy_ctl_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wd,
   output mode_fields_t      fields
);
   localparam int FIELD_W = $bits(mode_fields_t);

   initial assert (DATA_W > FIELD_W) else $error("phy_mode_reg: DATA_W too small");

   mode_fields_t q;
   mode_fields_t wr_fields;

   always_comb begin
      wr_fields = mode_fields_t'(wd[FIELD_W-1:0]);
      if (wr_fields.lb == LB_ILLEGAL) wr_fields.lb = q.lb;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (wr) q <= wr_fields;
   end

   assign fields = q;

   assert_no_illegal_lb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      q.lb != LB_ILLEGAL);

   assert_lb_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wd[4:3] == LB_ILLEGAL) |=> $stable(q.lb));

endmodule

// File: rtl/phy_irq_bank.sv
module phy_irq_bank
   import phy_ctl_pkg::*;
#(
   parameter int NSRC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  irq_mode_e       mode,
   input  logic [NSRC-1:0] src,
   input  logic            clr,
   output logic [NSRC-1:0] stat
);
   initial assert (NSRC >= 1 && NSRC <= 8) else $error("phy_irq_bank: NSRC out of range");

   logic [NSRC-1:0] src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src;
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      logic nxt;
      logic rise;

      assign rise = src[i] & ~src_q[i];

      always_comb begin
         unique case (mode)
            IM_STICKY: nxt = src[i] | (stat[i] & ~clr);
            IM_LEVEL:  nxt = src[i];
            default:   nxt = clr ? 1'b0 : (stat[i] | rise);
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat[i] <= 1'b0;
         else        stat[i] <= nxt;
      end

      assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == IM_STICKY && stat[i] && !clr) |=> stat[i]);

      assert_src_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == IM_STICKY && src[i]) |=> stat[i]);

      assert_level_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == IM_LEVEL) |=> (stat[i] == $past(src[i])));

      assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == IM_RDCLR && clr) |=> !stat[i]);
   end

endmodule

// File: rtl/phy_ctl_irq.sv
module phy_ctl_irq
   import phy_ctl_pkg::*;
#(
   parameter int          NSRC      = 4,
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 8,
   parameter logic [7:0]  MODE_ADDR = 8'h04,
   parameter logic [7:0]  STAT_ADDR = 8'h05,
   parameter logic [7:0]  EN_ADDR   = 8'h06
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rdata,
   input  logic [NSRC-1:0]   src,
   output logic [NSRC-1:0]   stat,
   output logic              irq,
   output logic [1:0]        lb_sel,
   output logic              free_unassigned,
   output logic              rx_synth,
   output logic              ool_keep
);
   localparam int FIELD_W = $bits(mode_fields_t);
   localparam int PAD_W   = DATA_W - NSRC;

   initial assert (NSRC <= DATA_W && DATA_W == 8 && ADDR_W == 8)
      else $error("phy_ctl_irq: unsupported widths");

   mode_fields_t    fields;
   logic [NSRC-1:0] en_q;
   logic            irq_q;
   logic            hit_mode, hit_stat, hit_en;

   assign hit_mode = (addr == MODE_ADDR);
   assign hit_stat = (addr == STAT_ADDR);
   assign hit_en   = (addr == EN_ADDR);

   phy_mode_reg #(.DATA_W(DATA_W)) u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_en & hit_mode),
      .wd     (wdata),
      .fields (fields)
   );

   phy_irq_bank #(.NSRC(NSRC)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (decode_imode(fields.imode)),
      .src   (src),
      .clr   (rd_en & hit_stat),
      .stat  (stat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         irq_q <= 1'b0;
      end else begin
         if (wr_en && hit_en) en_q <= wdata[NSRC-1:0];
         irq_q <= |(stat & en_q);
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_mode)      rdata = {{(DATA_W-FIELD_W){1'b0}}, fields};
      else if (hit_stat) rdata = {{PAD_W{1'b0}}, stat};
      else if (hit_en)   rdata = {{PAD_W{1'b0}}, en_q};
   end

   assign irq             = irq_q;
   assign lb_sel          = fields.lb;
   assign free_unassigned = fields.free_unassigned;
   assign rx_synth        = fields.rx_synth;
   assign ool_keep        = fields.ool_keep;

   assert_irq_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == $past(|(stat & en_q))));

   assert_bit7_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_mode |-> !rdata[DATA_W-1]);

endmodule

// File: tb/phy_ctl_irq_tb.sv
module phy_ctl_irq_tb;
   localparam int CLK_P = 10;
   localparam int N = 4;

   logic clk = 0, rst_n = 0;
   logic [7:0] addr = 0, wdata = 0, rdata;
   logic wr_en = 0, rd_en = 0;
   logic [N-1:0] src = 0, stat;
   logic irq, free_unassigned, rx_synth, ool_keep;
   logic [1:0] lb_sel;

   int cmp = 0, bad = 0;
   bit done = 0;

   logic [6:0] mode_m = 0;
   logic [N-1:0] en_m = 0, stat_m = 0, sprev = 0;

   always #(CLK_P/2) clk = ~clk;

   phy_ctl_irq u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .rdata(rdata), .src(src), .stat(stat), .irq(irq),
      .lb_sel(lb_sel), .free_unassigned(free_unassigned), .rx_synth(rx_synth),
      .ool_keep(ool_keep)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      cmp++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic string stat_tag(input logic [1:0] im, input logic clr, input logic [N-1:0] s);
      if (im == 2'd0) return (clr && s != 0) ? "R6" : "R5";
      if (im == 2'd1) return "R7";
      if (im == 2'd2) return "R8";
      return "R9";
   endfunction

   task automatic cyc(input logic [N-1:0] s, input logic rd, input logic [7:0] ra,
                      input logic wr, input logic [7:0] wa, input logic [7:0] wd);
      logic clr, exp_irq;
      logic [N-1:0] nx;
      logic [1:0] lb;
      string tag;
      @(negedge clk);
      src = s; rd_en = rd; wr_en = wr; wdata = wd;
      addr = rd ? ra : wa;
      #1;
      if (rd) begin
         if (ra == 8'h04)      chk("R2", rdata, {1'b0, mode_m});
         else if (ra == 8'h05) chk("R11", rdata, {{(8-N){1'b0}}, stat_m});
         else if (ra == 8'h06) chk("R10", rdata, {{(8-N){1'b0}}, en_m});
      end
      clr = rd && ra == 8'h05;
      tag = stat_tag(mode_m[1:0], clr, s);
      for (int i = 0; i < N; i++) begin
         case (mode_m[1:0])
            2'd0:    nx[i] = s[i] | (stat_m[i] & ~clr);
            2'd1:    nx[i] = s[i];
            default: nx[i] = clr ? 1'b0 : (stat_m[i] | (s[i] & ~sprev[i]));
         endcase
      end
      exp_irq = |(stat_m & en_m);
      stat_m = nx; sprev = s;
      if (wr && wa == 8'h04) begin
         lb = (wd[4:3] == 2'b11) ? mode_m[4:3] : wd[4:3];
         mode_m = {wd[6:5], lb, wd[2:0]};
      end
      if (wr && wa == 8'h06) en_m = wd[N-1:0];
      @(posedge clk);
      #1;
      chk(tag, {{(8-N){1'b0}}, stat}, {{(8-N){1'b0}}, stat_m});
      chk("R10", {7'd0, irq}, {7'd0, exp_irq});
      chk((wr && wa == 8'h04 && wd[4:3] == 2'b11) ? "R3" : "R4",
          {2'b0, ool_keep, free_unassigned, lb_sel, rx_synth, 1'b0},
          {2'b0, mode_m[6], mode_m[5], mode_m[4:3], mode_m[2], 1'b0});
      @(negedge clk);
      rd_en = 0; wr_en = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; cmp++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] lfsr;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1", {7'd0, irq}, 8'd0);
      chk("R1", {{(8-N){1'b0}}, stat}, 8'd0);
      addr = 8'h04; #1; chk("R1", rdata, 8'h00);
      addr = 8'h06; #1; chk("R1", rdata, 8'h00);
      @(negedge clk); rst_n = 1;

      // R2, R3, R4: exhaustive mode-register writes with readback
      for (int v = 0; v < 256; v++) begin
         cyc('0, 0, 0, 1, 8'h04, v[7:0]);
         cyc('0, 1, 8'h04, 0, 0, 0);
      end

      // R10: enable register readback
      for (int v = 0; v < 16; v++) begin
         cyc('0, 0, 0, 1, 8'h06, {4'hA, v[3:0]});
         cyc('0, 1, 8'h06, 0, 0, 0);
      end

      // Sweep every interrupt mode code with pseudo-random sources and reads
      lfsr = 8'h5B;
      for (int m = 0; m < 4; m++) begin
         cyc('0, 0, 0, 1, 8'h04, m[7:0]);
         cyc('0, 0, 0, 1, 8'h06, 8'h0F);
         for (int k = 0; k < 120; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cyc(lfsr[3:0], lfsr[5] | lfsr[6], 8'h05, 0, 0, 0);
         end
         // R11: write to status address is ignored
         cyc(4'b0101, 0, 0, 1, 8'h05, 8'hFF);
         cyc('0, 0, 0, 1, 8'h05, 8'h00);
         cyc('0, 1, 8'h05, 0, 0, 0);
         cyc('0, 1, 8'h05, 0, 0, 0);
      end

      // R6: sticky, read while source held high keeps the bit
      cyc('0, 0, 0, 1, 8'h04, 8'h00);
      cyc(4'b0001, 0, 0, 0, 0, 0);
      cyc(4'b0001, 1, 8'h05, 0, 0, 0);
      cyc(4'b0000, 1, 8'h05, 0, 0, 0);
      cyc(4'b0000, 1, 8'h05, 0, 0, 0);

      // R8: read-clear, read on rising edge wins; re-set on next rise only
      cyc('0, 0, 0, 1, 8'h04, 8'h02);
      cyc(4'b0000, 0, 0, 0, 0, 0);
      cyc(4'b0010, 1, 8'h05, 0, 0, 0);
      cyc(4'b0010, 0, 0, 0, 0, 0);
      cyc(4'b0000, 0, 0, 0, 0, 0);
      cyc(4'b0010, 0, 0, 0, 0, 0);
      cyc(4'b0010, 1, 8'h05, 0, 0, 0);
      cyc(4'b0010, 0, 0, 0, 0, 0);

      // R10: partial enable gating
      cyc('0, 0, 0, 1, 8'h04, 8'h01);
      cyc('0, 0, 0, 1, 8'h06, 8'h04);
      cyc(4'b0011, 0, 0, 0, 0, 0);
      cyc(4'b0011, 0, 0, 0, 0, 0);
      cyc(4'b0100, 0, 0, 0, 0, 0);
      cyc(4'b0100, 0, 0, 0, 0, 0);
      cyc(4'b0000, 0, 0, 0, 0, 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
      $finish;
   end
endmodule